// File: doc/BRIEF.md
# Shared Machine Timer and Software Interrupt Unit

This unit serves a group of harts whose IDs need not be contiguous. It keeps one 64-bit time counter, a 64-bit compare value for each hart and a software-interrupt bit for each hart. From these it drives one timer-interrupt line and one software-interrupt line to every hart. The counter advances each cycle by an amount given on an input. A parameter mask says which hart IDs exist. A hart whose mask bit is clear keeps no state: its slots read as zero and writes to them have no effect.

Software reaches the registers through a byte-addressed port. Each request has an address, a length from 1 to 8 bytes and write data. Read data and the error flag are combinational and belong to the request being presented. A write takes effect on the clock edge on which it is presented. A partial access uses little-endian byte lanes inside the register it hits and wraps within that register.

Top module: `hart_timer_swi`

## Requirements
- R1: A request with a length of 0 or more than 8 sets `bus_err`, returns zero read data and changes no state.
- R2: An address at or above 0xC000 sets `bus_err` and returns zero read data. Every address below 0xC000 is accepted.
- R3: The software-interrupt slot of hart h sits at offset 4*h in the region below 0x4000. Reading it returns 1 in bit 0 when the hart exists and its bit is set, and 0 otherwise. A write loads bit 0 of the assembled 32-bit word into the hart's bit. `soft_irq[h]` shows the bit.
- R4: A software-slot write assembles its 32-bit word from zero. Transfer byte i goes to word byte (addr+i) mod 4. A write that does not cover byte 0 therefore clears the bit.
- R5: An 8-byte request in the software region acts as two 4-byte requests: lanes 0-3 go to the slot at addr, and lanes 4-7 go to the slot at addr+4. Lengths 5, 6 and 7 in that region set `bus_err`.
- R6: The compare register of hart h sits at 0x4000+8*h. Transfer byte i maps to register byte (addr+i) mod 8. A write changes only the bytes it covers.
- R7: A hart whose mask bit is clear, or whose ID is NUM_HARTS or more, reads zero in both of its slots. Writes to those slots are ignored, and both of its interrupt lines stay low.
- R8: The time counter sits at 0xBFF8..0xBFFF and uses the same 8-byte lane rule as R6. In every cycle without a successful write to it, it advances by `tick_inc`. In a cycle with such a write, it takes the written bytes and does not advance.
- R9: `timer_irq[h]` is high exactly when hart h exists and the current counter value is greater than or equal to its compare value. It follows every change of either register in the same cycle.
- R10: After reset the counter is 0, every software bit is 0 and every compare register holds all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_inc | input | INC_W | Amount added to the counter each cycle |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Byte address inside the unit |
| bus_len | input | 4 | Transfer length in bytes |
| bus_wdata | input | 64 | Write data; byte i sits in bits 8i+7..8i |
| bus_rdata | output | 64 | Read data, same lane layout |
| bus_err | output | 1 | Request rejected |
| timer_irq | output | NUM_HARTS | Timer interrupt, one bit per hart |
| soft_irq | output | NUM_HARTS | Software interrupt, one bit per hart |

## Verification
The hardest behaviour to reach is the timer line crossing its threshold. The reset compare value of all ones is never reached, so the compare value has to be brought close to the running counter before the comparison can flip. The stimulus writes compare and counter values drawn near the model's current count, so both directions of the crossing occur often. Unaligned and wrapping lane accesses, 8-byte software accesses and holes in the hart mask are mixed into the same random stream.

// File: rtl/hart_timer_swi.sv
module hart_timer_swi #(
  parameter int NUM_HARTS = 4,
  parameter logic [NUM_HARTS-1:0] HART_MASK = 4'b1011,
  parameter int INC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [INC_W-1:0]     tick_inc,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [15:0]          bus_addr,
  input  logic [3:0]           bus_len,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_HARTS-1:0] timer_irq,
  output logic [NUM_HARTS-1:0] soft_irq
);
  localparam logic [15:0] CMP_BASE  = 16'h4000;
  localparam logic [15:0] TIME_BASE = 16'hBFF8;
  localparam logic [15:0] WIN_END   = 16'hC000;
  localparam int HW = 14;

  logic [63:0] time_q;
  logic [63:0] cmp_q [NUM_HARTS];
  logic        sw_q  [NUM_HARTS];

  function automatic logic [63:0] rd_lanes(input logic [63:0] r, input logic [2:0] a,
                                           input logic [3:0] n);
    logic [63:0] o;
    o = '0;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] s;
      s = a + 3'(i);
      if (4'(i) < n) o[8*i +: 8] = r[{s, 3'b000} +: 8];
    end
    return o;
  endfunction

  function automatic logic [63:0] wr_lanes(input logic [63:0] r, input logic [2:0] a,
                                           input logic [3:0] n, input logic [63:0] d);
    logic [63:0] o;
    o = r;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] i;
      i = 3'(k) - a;
      if ({1'b0, i} < n) o[8*k +: 8] = d[{i, 3'b000} +: 8];
    end
    return o;
  endfunction

  wire in_sw   = bus_addr < CMP_BASE;
  wire in_time = bus_addr >= TIME_BASE && bus_addr < WIN_END;
  wire in_cmp  = !in_sw && bus_addr < TIME_BASE;
  wire bad_len = bus_len == 4'd0 || bus_len > 4'd8 ||
                 (in_sw && bus_len > 4'd4 && bus_len != 4'd8);

  assign bus_err = bus_valid && (bad_len || bus_addr >= WIN_END);
  wire wr_en = bus_valid && bus_write && !bus_err;

  wire [HW-1:0] sw_lo  = bus_addr[15:2];
  wire [HW-1:0] sw_hi  = sw_lo + 1'b1;
  wire [HW-1:0] cmp_h  = HW'((bus_addr - CMP_BASE) >> 3);
  wire [3:0]    sw_n   = (bus_len == 4'd8) ? 4'd4 : bus_len;
  wire [1:0]    b0_lane = 2'd0 - bus_addr[1:0];
  wire          lo_cov = {2'b00, b0_lane} < sw_n;
  wire          lo_bit = lo_cov && bus_wdata[{1'b0, b0_lane, 3'b000}];
  wire          hi_bit = bus_wdata[{1'b1, b0_lane, 3'b000}];

  function automatic logic sw_of(input logic [HW-1:0] h);
    logic r;
    r = 1'b0;
    for (int g = 0; g < NUM_HARTS; g++) if (h == HW'(g)) r = sw_q[g];
    return r;
  endfunction

  function automatic logic [63:0] cmp_of(input logic [HW-1:0] h);
    logic [63:0] r;
    r = '0;
    for (int g = 0; g < NUM_HARTS; g++) if (h == HW'(g)) r = cmp_q[g];
    return r;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write && !bus_err) begin
      if (in_sw) begin
        if (lo_cov) bus_rdata[{1'b0, b0_lane, 3'b000}] = sw_of(sw_lo);
        if (bus_len == 4'd8) bus_rdata[{1'b1, b0_lane, 3'b000}] = sw_of(sw_hi);
      end else if (in_cmp) begin
        bus_rdata = rd_lanes(cmp_of(cmp_h), bus_addr[2:0], bus_len);
      end else begin
        bus_rdata = rd_lanes(time_q, bus_addr[2:0], bus_len);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) time_q <= '0;
    else if (wr_en && in_time) time_q <= wr_lanes(time_q, bus_addr[2:0], bus_len, bus_wdata);
    else time_q <= time_q + 64'(tick_inc);

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    if (HART_MASK[g]) begin : g_on
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          cmp_q[g] <= '1;
          sw_q[g]  <= 1'b0;
        end else if (wr_en) begin
          if (in_sw && sw_lo == HW'(g)) sw_q[g] <= lo_bit;
          else if (in_sw && bus_len == 4'd8 && sw_hi == HW'(g)) sw_q[g] <= hi_bit;
          if (in_cmp && cmp_h == HW'(g))
            cmp_q[g] <= wr_lanes(cmp_q[g], bus_addr[2:0], bus_len, bus_wdata);
        end
    end else begin : g_off
      assign cmp_q[g] = '0;
      assign sw_q[g]  = 1'b0;
    end
    assign timer_irq[g] = HART_MASK[g] && time_q >= cmp_q[g];
    assign soft_irq[g]  = sw_q[g];
  end
endmodule

module hart_timer_swi_chk #(
  parameter int NUM_HARTS = 4,
  parameter logic [NUM_HARTS-1:0] HART_MASK = 4'b1011,
  parameter int INC_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [INC_W-1:0]     tick_inc,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [15:0]          bus_addr,
  input logic [3:0]           bus_len,
  input logic [63:0]          bus_rdata,
  input logic                 bus_err,
  input logic [NUM_HARTS-1:0] soft_irq,
  input logic [63:0]          time_q
);
  wire time_wr = bus_valid && bus_write && !bus_err && bus_addr >= 16'hBFF8;

  assert_len_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_len > 4'd8 |-> bus_err && bus_rdata == 64'd0);

  assert_err_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_err |=> $stable(soft_irq));

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_addr >= 16'hC000 |-> bus_err && bus_rdata == 64'd0);

  assert_missing_hart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && !bus_err && bus_addr < 16'h4000 && bus_len <= 4'd4 &&
    bus_addr[15:2] >= 14'(NUM_HARTS) |=> $stable(soft_irq));

  assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !time_wr |=> time_q == $past(time_q) + 64'($past(tick_inc)));

  assert_time_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_addr == 16'hBFF8 && bus_len == 4'd8 |-> bus_rdata == time_q);
endmodule

bind hart_timer_swi hart_timer_swi_chk #(
  .NUM_HARTS(NUM_HARTS), .HART_MASK(HART_MASK), .INC_W(INC_W)
) u_chk (.*);

// File: tb/sim_hart_timer_swi.sv
`timescale 1ns/1ps
module sim_hart_timer_swi;
  localparam int NH = 4;
  localparam logic [NH-1:0] MASK = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  tick_inc = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [3:0]  bus_len = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_err;
  logic [NH-1:0] timer_irq, soft_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [63:0] m_time;
  logic [63:0] m_cmp [NH];
  bit          m_sw  [NH];

  always #4 clk = ~clk;

  hart_timer_swi #(.NUM_HARTS(NH), .HART_MASK(MASK), .INC_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_inc(tick_inc), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_len(bus_len),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .timer_irq(timer_irq), .soft_irq(soft_irq));

  function automatic bit present(int h);
    return h >= 0 && h < NH && MASK[h];
  endfunction

  function automatic bit exp_err(logic [15:0] a, logic [3:0] n);
    return n == 0 || n > 8 || a >= 16'hC000 || (a < 16'h4000 && n > 4 && n != 8);
  endfunction

  function automatic logic [63:0] exp_rd(logic [15:0] a, logic [3:0] n);
    logic [63:0] o;
    o = '0;
    for (int i = 0; i < n; i++) begin
      if (a < 16'h4000) begin
        int hf, h;
        hf = (n == 8) ? i / 4 : 0;
        h = (int'(a) + 4 * hf) / 4;
        if ((int'(a) + i) % 4 == 0 && present(h) && m_sw[h]) o[8*i] = 1'b1;
      end else if (a < 16'hBFF8) begin
        int h, b;
        h = (int'(a) - 'h4000) / 8;
        b = (int'(a) + i) % 8;
        if (present(h)) o[8*i +: 8] = m_cmp[h][8*b +: 8];
      end else begin
        int b;
        b = (int'(a) + i) % 8;
        o[8*i +: 8] = m_time[8*b +: 8];
      end
    end
    return o;
  endfunction

  task automatic check(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, bit wr, logic [15:0] a, logic [3:0] n,
                    logic [63:0] d, logic [7:0] inc);
    bit e;
    logic [NH-1:0] et, es;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_len = n;
    bus_wdata = d; tick_inc = inc;
    #1;
    e = exp_err(a, n);
    check({tag, " err"}, bus_err == e, 64'(bus_err), 64'(e));
    if (!wr) check({tag, " rdata"}, bus_rdata == (e ? 64'd0 : exp_rd(a, n)),
                   bus_rdata, e ? 64'd0 : exp_rd(a, n));
    for (int h = 0; h < NH; h++) begin
      et[h] = present(h) && m_time >= m_cmp[h];
      es[h] = present(h) && m_sw[h];
    end
    check("R9 timer_irq", timer_irq == et, 64'(timer_irq), 64'(et));
    check("R3 soft_irq", soft_irq == es, 64'(soft_irq), 64'(es));
    @(posedge clk);
    if (wr && !e && a >= 16'hBFF8) begin
      for (int i = 0; i < n; i++) begin
        int b;
        b = (int'(a) + i) % 8;
        m_time[8*b +: 8] = d[8*i +: 8];
      end
    end else begin
      m_time = m_time + 64'(inc);
      if (wr && !e && a < 16'h4000) begin
        for (int hf = 0; hf < ((n == 8) ? 2 : 1); hf++) begin
          logic [31:0] w;
          int nh, h;
          w = '0;
          nh = (n == 8) ? 4 : int'(n);
          for (int j = 0; j < nh; j++) w[8*((int'(a) + j) % 4) +: 8] = d[8*(4*hf + j) +: 8];
          h = (int'(a) + 4 * hf) / 4;
          if (present(h)) m_sw[h] = w[0];
        end
      end else if (wr && !e) begin
        int h;
        h = (int'(a) - 'h4000) / 8;
        if (present(h))
          for (int i = 0; i < n; i++) m_cmp[h][8*((int'(a) + i) % 8) +: 8] = d[8*i +: 8];
      end
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_time = '0;
    for (int h = 0; h < NH; h++) begin m_cmp[h] = '1; m_sw[h] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset values
    op("R10 time", 0, 16'hBFF8, 8, 0, 0);
    op("R10 cmp", 0, 16'h4000, 8, 0, 0);
    op("R10 sw", 0, 16'h0004, 4, 0, 0);
    // R9 threshold crossing
    op("R6 cmp wr", 1, 16'h4008, 8, 64'd5, 1);
    repeat (8) op("R9 count", 0, 16'hBFF8, 8, 0, 1);
    op("R6 cmp raise", 1, 16'h4008, 8, 64'd100, 0);
    op("R9 after raise", 0, 16'h4008, 8, 0, 0);
    // R3 / R4
    op("R3 set", 1, 16'h0000, 1, 64'h01, 0);
    op("R3 read", 0, 16'h0000, 4, 0, 0);
    op("R4 byte1 wr", 1, 16'h0001, 1, 64'hFF, 0);
    op("R4 read", 0, 16'h0000, 4, 0, 0);
    op("R4 wrap wr", 1, 16'h0002, 4, 64'h0000_0100, 0);
    op("R4 wrap rd", 0, 16'h0002, 4, 0, 0);
    // R5 double access
    op("R5 dbl wr", 1, 16'h0000, 8, 64'h0000_0001_0000_0001, 0);
    op("R5 dbl rd", 0, 16'h0000, 8, 0, 0);
    op("R5 len6", 1, 16'h0000, 6, 0, 0);
    op("R5 len6 rd", 0, 16'h0004, 4, 0, 0);
    // R7 missing hart
    op("R7 sw wr", 1, 16'h0008, 4, 64'h1, 0);
    op("R7 sw rd", 0, 16'h0008, 4, 0, 0);
    op("R7 cmp wr", 1, 16'h4010, 8, 64'h0, 0);
    op("R7 cmp rd", 0, 16'h4010, 8, 0, 0);
    op("R7 far rd", 0, 16'h4100, 8, 0, 0);
    // R1 / R2
    op("R1 len9", 1, 16'h4000, 9, 0, 0);
    op("R1 len0", 0, 16'hBFF8, 0, 0, 0);
    op("R2 window", 0, 16'hC000, 4, 0, 0);
    // R6 wrapping partial
    op("R6 wrap wr", 1, 16'h4006, 4, 64'hA1B2_C3D4, 0);
    op("R6 wrap rd", 0, 16'h4000, 8, 0, 0);
    // R8 counter write
    op("R8 time wr", 1, 16'hBFFC, 2, 64'hBEEF, 3);
    op("R8 time rd", 0, 16'hBFF8, 8, 0, 3);

    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a;
      logic [3:0] n;
      logic [63:0] d;
      string tag;
      int sel;
      sel = $urandom % 10;
      n = ($urandom % 8 == 0) ? 4'($urandom % 11) : 4'(1 + $urandom % 8);
      d = {$urandom, $urandom};
      if (sel < 3) begin
        a = 16'(($urandom % 6) * 4 + $urandom % 4);
        tag = "R3 rnd";
      end else if (sel < 6) begin
        a = 16'h4000 + 16'(($urandom % 6) * 8);
        if ($urandom % 2) n = 8; else a = a + 16'($urandom % 8);
        if ($urandom % 2) d = m_time + 64'($urandom % 64);
        tag = "R6 rnd";
      end else if (sel < 8) begin
        a = 16'hBFF8 + 16'($urandom % 8);
        if ($urandom % 2) begin a = 16'hBFF8; n = 8; end
        if ($urandom % 4 == 0) d = m_time - 64'($urandom % 64);
        tag = "R8 rnd";
      end else if (sel < 9) begin
        a = 16'hC000 + 16'($urandom % 16'h3000);
        tag = "R2 rnd";
      end else begin
        a = 16'($urandom);
        tag = "R1 rnd";
      end
      op(tag, 1'($urandom % 2), a, n, d, 8'($urandom % 4));
    end

    @(negedge clk);
    bus_valid = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule